// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break Detection

This block is the receive half of a programmable serial controller, working in asynchronous mode only. It watches the serial input line on a receive clock that runs at 1, 16 or 64 times the bit rate. It finds a start bit, gathers a character of 5 to 8 data bits sent least significant bit first, and then reads an optional parity bit and a stop bit. The finished character goes into a holding register for the host.

A ready flag tells the host that a character is waiting, and a one-cycle read strobe clears it. If a new character completes before the old one is read, the old one is overwritten and an overrun flag is set. Framing, parity and overrun flags are sticky until an error-clear pulse. A break output goes high when the line stays low through the stop positions of two consecutive characters, and it drops as soon as the line returns high. The input line passes through a two-stage synchronizer before the state machine sees it.

The state machine has five states. IDLE waits for a low line while receive is enabled, then goes to START, or straight to DATA at factor 1. START waits half a bit time, then goes to DATA if the line is still low, or back to IDLE (glitch). DATA shifts in one bit per bit time, then goes to PARITY if parity is enabled, otherwise to STOP. PARITY captures one bit and goes to STOP. STOP samples the stop bit, reports the character and returns to IDLE. Any state returns to IDLE while receive is disabled.

Top module: `async_rx_break`

## Requirements
- R1: `rate_sel` picks the clock-to-bit ratio: 2'b00 gives 1, 2'b01 gives 16, and 2'b10 or 2'b11 give 64. Each bit is sampled near its middle.
- R2: `char_len` picks the data length: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Bits arrive least significant first. The character is right-justified in `rx_data`, and the unused upper bits read 0.
- R3: At ratios 16 and 64, a low level that is gone by the middle of the start bit is treated as a glitch and produces no character.
- R4: `rx_rdy` rises when a character is complete and falls after a cycle with `rd_stb` high.
- R5: If a character completes while `rx_rdy` is still high, `rx_data` takes the new character and `ovr_err` is set.
- R6: `frm_err` is set when the sampled stop bit is 0.
- R7: With `par_en` high, `par_err` is set when the data bits plus the parity bit have an odd number of ones (`par_odd`=0) or an even number (`par_odd`=1).
- R8: `ovr_err`, `frm_err` and `par_err` stay set, even after a read, until an `err_clr` pulse clears them.
- R9: `brk_det` rises when the stop bits of two consecutive characters are both sampled low with no high level on the line in between.
- R10: Once set, `brk_det` stays high while the line is low and clears within a few cycles after the line goes high.
- R11: While `rx_en` is low, no character is received and `rx_rdy` does not rise.
- R12: At ratio 1, each bit is taken on one clock edge, with no mid-bit start check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock (1, 16 or 64 times the bit rate) |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receive enable |
| rate_sel | input | 2 | Clock-to-bit ratio select |
| char_len | input | 2 | Data bits per character select |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rxd | input | 1 | Serial input line, idle high |
| rd_stb | input | 1 | Host read pulse for the holding register |
| err_clr | input | 1 | Pulse that clears the sticky error flags |
| rx_data | output | 8 | Holding register, right-justified |
| rx_rdy | output | 1 | Character waiting |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| brk_det | output | 1 | Line break detected |

## Verification
The assertions assume that `rate_sel`, `char_len`, `par_en` and `par_odd` hold steady while a character is in flight. They also assume that `rd_stb` and `err_clr` are single-cycle pulses that do not collide with a character completing. The bench changes configuration only while the line has been idle for at least two bit times. It issues reads and clears only after the character's flags have settled. The mix of random frames at each ratio is followed by directed cases for a glitch, an overrun, a disabled receiver and a held-low line.

// File: rtl/rx_pkg.sv
package rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_fsm.sv
module rx_fsm
    import rx_pkg::*;
#(
    parameter int MAX_BITS   = 8,
    parameter int MAX_FACTOR = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_en,
    input  logic [1:0]          rate_sel,
    input  logic [1:0]          char_len,
    input  logic                par_en,
    input  logic                rxs,
    output logic                done,
    output logic [MAX_BITS-1:0] word,
    output logic                pbit,
    output logic                stop_bit
);
    localparam int CNT_W = $clog2(MAX_FACTOR);
    localparam int IDX_W = $clog2(MAX_BITS + 1);

    rx_state_t state, nxt;
    logic [CNT_W-1:0]    cnt;
    logic [IDX_W-1:0]    bidx;
    logic [MAX_BITS-1:0] shreg;
    logic [CNT_W:0]      fac;
    logic [CNT_W:0]      half_last;
    logic [IDX_W-1:0]    nbits;
    logic                sample;
    logic                mid_start;
    logic                last_bit;

    always_comb begin
        unique case (rate_sel)
            2'b00:   fac = (CNT_W+1)'(1);
            2'b01:   fac = (CNT_W+1)'(16);
            default: fac = (CNT_W+1)'(64);
        endcase
    end

    assign half_last = (fac >> 1) - 1'b1;
    assign sample    = ({1'b0, cnt} == (fac - 1'b1));
    assign mid_start = ({1'b0, cnt} == half_last);
    assign nbits     = IDX_W'(char_len) + IDX_W'(5);
    assign last_bit  = (bidx == nbits - 1'b1);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!rxs) nxt = (fac == (CNT_W+1)'(1)) ? ST_DATA : ST_START;
            ST_START:  if (mid_start) nxt = rxs ? ST_IDLE : ST_DATA;
            ST_DATA:   if (sample && last_bit) nxt = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (sample) nxt = ST_STOP;
            ST_STOP:   if (sample) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        if (!rx_en) nxt = ST_IDLE;
    end

    // datapath: bit timer, bit index, shift register
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            bidx  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
        end else begin
            if (state == ST_IDLE || state != nxt || sample) cnt <= '0;
            else                                            cnt <= cnt + 1'b1;

            if (state == ST_IDLE) begin
                bidx  <= '0;
                shreg <= '0;
            end else if (state == ST_DATA && sample) begin
                bidx  <= bidx + 1'b1;
                shreg <= {rxs, shreg[MAX_BITS-1:1]};
            end

            if (state == ST_PARITY && sample) pbit <= rxs;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            word     <= '0;
            stop_bit <= 1'b1;
        end else begin
            done <= rx_en && (state == ST_STOP) && sample;
            if (state == ST_STOP && sample) begin
                word     <= shreg >> (IDX_W'(MAX_BITS) - nbits);
                stop_bit <= rxs;
            end
        end
    end

    assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (state == ST_IDLE) && !done);

    assert_start_held_low_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_START) |-> !$past(rxs));
endmodule

// File: rtl/rx_status.sv
module rx_status #(
    parameter int MAX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                done,
    input  logic [MAX_BITS-1:0] word,
    input  logic                pbit,
    input  logic                stop_bit,
    input  logic                rxs,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                rd_stb,
    input  logic                err_clr,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_rdy,
    output logic                ovr_err,
    output logic                frm_err,
    output logic                par_err,
    output logic                brk_det
);
    logic low_stop_seen;
    logic bad_par;
    logic bad_stop;

    assign bad_par  = par_en && ((^word ^ pbit) != par_odd);
    assign bad_stop = !stop_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data       <= '0;
            rx_rdy        <= 1'b0;
            ovr_err       <= 1'b0;
            frm_err       <= 1'b0;
            par_err       <= 1'b0;
            brk_det       <= 1'b0;
            low_stop_seen <= 1'b0;
        end else begin
            if (done) begin
                rx_data <= word;
                rx_rdy  <= 1'b1;
            end else if (rd_stb) begin
                rx_rdy  <= 1'b0;
            end

            if (done && rx_rdy && !rd_stb) ovr_err <= 1'b1;
            else if (err_clr)              ovr_err <= 1'b0;

            if (done && bad_stop) frm_err <= 1'b1;
            else if (err_clr)     frm_err <= 1'b0;

            if (done && bad_par) par_err <= 1'b1;
            else if (err_clr)    par_err <= 1'b0;

            if (rxs)                   low_stop_seen <= 1'b0;
            else if (done && bad_stop) low_stop_seen <= 1'b1;

            if (rxs)                                    brk_det <= 1'b0;
            else if (done && bad_stop && low_stop_seen) brk_det <= 1'b1;
        end
    end

    assert_rdy_falls_on_read_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_rdy) |-> $past(rd_stb));

    assert_ovr_needs_unread_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_err) |-> $past(rx_rdy) && $past(done));

    assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(ovr_err) || $fell(frm_err) || $fell(par_err)) |-> $past(err_clr));

    assert_brk_holds_low_R10: assert property (@(posedge clk) disable iff (rst)
        (brk_det && !rxs) |=> brk_det);

    assert_brk_clears_high_R10: assert property (@(posedge clk) disable iff (rst)
        (brk_det && rxs) |=> !brk_det);

    assert_brk_needs_bad_stop_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_det) |-> $past(done) && !$past(stop_bit));
endmodule

// File: rtl/async_rx_break.sv
module async_rx_break #(
    parameter int MAX_BITS    = 8,
    parameter int MAX_FACTOR  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_en,
    input  logic [1:0]          rate_sel,
    input  logic [1:0]          char_len,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                rxd,
    input  logic                rd_stb,
    input  logic                err_clr,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_rdy,
    output logic                ovr_err,
    output logic                frm_err,
    output logic                par_err,
    output logic                brk_det
);
    logic                rxs;
    logic                done;
    logic [MAX_BITS-1:0] word;
    logic                pbit;
    logic                stop_bit;

    rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (rxd),
        .q   (rxs)
    );

    rx_fsm #(.MAX_BITS(MAX_BITS), .MAX_FACTOR(MAX_FACTOR)) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .rx_en    (rx_en),
        .rate_sel (rate_sel),
        .char_len (char_len),
        .par_en   (par_en),
        .rxs      (rxs),
        .done     (done),
        .word     (word),
        .pbit     (pbit),
        .stop_bit (stop_bit)
    );

    rx_status #(.MAX_BITS(MAX_BITS)) status_i (
        .clk      (clk),
        .rst      (rst),
        .done     (done),
        .word     (word),
        .pbit     (pbit),
        .stop_bit (stop_bit),
        .rxs      (rxs),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .rd_stb   (rd_stb),
        .err_clr  (err_clr),
        .rx_data  (rx_data),
        .rx_rdy   (rx_rdy),
        .ovr_err  (ovr_err),
        .frm_err  (frm_err),
        .par_err  (par_err),
        .brk_det  (brk_det)
    );
endmodule

// File: tb/async_rx_break_tb_top.sv
module async_rx_break_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] rate_sel = 2'b01;
    logic [1:0] char_len = 2'b11;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_stb = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_rdy, ovr_err, frm_err, par_err, brk_det;

    int  n_cmp = 0;
    int  n_mis = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    async_rx_break dut_i (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rate_sel(rate_sel),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .rxd(rxd),
        .rd_stb(rd_stb), .err_clr(err_clr), .rx_data(rx_data), .rx_rdy(rx_rdy),
        .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err), .brk_det(brk_det)
    );

    function automatic int fac_of(input logic [1:0] sel);
        return (sel == 2'b00) ? 1 : (sel == 2'b01) ? 16 : 64;
    endfunction

    function automatic logic [7:0] mask_of(input logic [1:0] len);
        return 8'hFF >> (3 - len);
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b, input int fac);
        rxd = b;
        repeat (fac) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic bad_p, input logic stop_lvl);
        int fac;
        int nb;
        fac = fac_of(rate_sel);
        nb  = 5 + int'(char_len);
        drive_bit(1'b0, fac);
        for (int i = 0; i < nb; i++) drive_bit(d[i], fac);
        if (par_en) drive_bit(par_bit(d & mask_of(char_len), par_odd) ^ bad_p, fac);
        drive_bit(stop_lvl, fac);
        rxd = 1'b1;
        repeat (2 * fac + 8) @(negedge clk);
    endtask

    task automatic pulse_rd();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_mis++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       bp, sl;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R4 reset rx_rdy", rx_rdy, 0);
        chk("R8 reset flags", {ovr_err, frm_err, par_err}, 0);
        chk("R9 reset brk_det", brk_det, 0);
        chk("R2 reset rx_data", rx_data, 0);

        // directed: ratio 64, 8 bits, no parity (R1)
        rate_sel = 2'b10; char_len = 2'b11; par_en = 1'b0;
        repeat (4) @(negedge clk);
        send(8'h3C, 1'b0, 1'b1);
        chk("R1 x64 data", rx_data, 8'h3C);
        chk("R4 rdy set", rx_rdy, 1);
        pulse_rd();
        chk("R4 rdy cleared", rx_rdy, 0);

        // directed: 5-bit length, upper bits zero (R2)
        rate_sel = 2'b01; char_len = 2'b00;
        repeat (4) @(negedge clk);
        send(8'hF5, 1'b0, 1'b1);
        chk("R2 5-bit data", rx_data, 8'h15);
        pulse_rd();

        // directed: ratio 1, even parity (R12)
        rate_sel = 2'b00; char_len = 2'b11; par_en = 1'b1; par_odd = 1'b0;
        repeat (4) @(negedge clk);
        send(8'hA5, 1'b0, 1'b1);
        chk("R12 x1 data", rx_data, 8'hA5);
        chk("R7 x1 parity ok", par_err, 0);
        pulse_rd();

        // directed: odd parity wrong (R7), then sticky (R8)
        rate_sel = 2'b01; par_odd = 1'b1;
        repeat (4) @(negedge clk);
        send(8'h81, 1'b1, 1'b1);
        chk("R7 odd parity error", par_err, 1);
        pulse_rd();
        chk("R8 parity sticky after read", par_err, 1);
        pulse_clr();
        chk("R8 parity cleared", par_err, 0);

        // directed: framing (R6)
        par_en = 1'b0;
        repeat (4) @(negedge clk);
        send(8'h5A, 1'b0, 1'b0);
        chk("R6 framing error", frm_err, 1);
        chk("R6 data kept", rx_data, 8'h5A);
        pulse_rd();
        pulse_clr();
        chk("R8 framing cleared", frm_err, 0);

        // random frames
        for (int k = 0; k < 40; k++) begin
            rate_sel = 2'($urandom_range(0, 3));
            char_len = 2'($urandom_range(0, 3));
            par_en   = 1'($urandom_range(0, 1));
            par_odd  = 1'($urandom_range(0, 1));
            d        = 8'($urandom);
            bp       = ($urandom_range(0, 7) == 0);
            sl       = ($urandom_range(0, 7) != 0);
            repeat (2 * fac_of(rate_sel) + 4) @(negedge clk);
            send(d, bp, sl);
            chk("R2 random data", rx_data, d & mask_of(char_len));
            chk("R4 random rdy", rx_rdy, 1);
            chk("R6 random framing", frm_err, !sl);
            chk("R7 random parity", par_err, par_en && bp);
            chk("R5 random no overrun", ovr_err, 0);
            pulse_rd();
            chk("R4 random rdy cleared", rx_rdy, 0);
            pulse_clr();
        end

        // overrun (R5)
        rate_sel = 2'b01; char_len = 2'b11; par_en = 1'b0;
        repeat (40) @(negedge clk);
        send(8'h11, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b1);
        chk("R5 overrun flag", ovr_err, 1);
        chk("R5 newer data kept", rx_data, 8'h22);
        pulse_rd();
        chk("R8 overrun sticky", ovr_err, 1);
        pulse_clr();
        chk("R8 overrun cleared", ovr_err, 0);

        // glitch on start (R3)
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        chk("R3 glitch ignored", rx_rdy, 0);
        send(8'h6E, 1'b0, 1'b1);
        chk("R3 frame after glitch", rx_data, 8'h6E);
        pulse_rd();

        // receiver disabled (R11)
        rx_en = 1'b0;
        repeat (4) @(negedge clk);
        send(8'h99, 1'b0, 1'b1);
        chk("R11 disabled no rdy", rx_rdy, 0);
        chk("R11 disabled data unchanged", rx_data, 8'h6E);
        rx_en = 1'b1;
        repeat (40) @(negedge clk);

        // line break (R9, R10)
        rxd = 1'b0;
        repeat (30 * 16) @(negedge clk);
        chk("R9 break detected", brk_det, 1);
        repeat (50) @(negedge clk);
        chk("R10 break held while low", brk_det, 1);
        rxd = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 break cleared on high", brk_det, 0);
        repeat (14 * 16) @(negedge clk);
        pulse_rd();
        pulse_clr();
        chk("R9 flags clear after break", {rx_rdy, ovr_err, frm_err, par_err}, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule